// File: doc/BRIEF.md
# SPI Flash Host Engine with Indexed Data Buffer

This block is a serial flash host engine. Software programs it through a byte-wide register port. It loads an opcode, a transmit count, a receive count and the transmit bytes, then sets a self-clearing execute bit. The engine lowers chip select and shifts out the opcode followed by the transmit bytes, most significant bit first, in SPI mode 0. It then clocks in the requested number of response bytes, sending all-ones bytes while it does so.

The data buffer is a 71-entry byte array that software addresses directly; it is not a FIFO. Transmit byte i is taken from entry i. Response byte i is written to entry (transmit count + i) modulo 71, so a long transmit phase makes the responses wrap around to the start of the buffer. The serial clock rate comes from the normal-access field of a 16-bit speed register, which holds four 4-bit clock selects. A 3-bit read-mode value is stored across two non-adjacent control bytes, and an enable bit gates the whole engine.

Top module: `spi_flash_engine`

## Requirements
- R1: After reset, every register reads 0x00, csN is 1 and sck is 0.
- R2: Register readback. Offset 0x00 holds the opcode, 0x48 the transmit count and 0x4B the receive count. Offset 0x20 bit 0 is the enable. Offset 0x22 is speed bits 7:0 and 0x23 is speed bits 15:8 (normal select 15:12, fast 11:8, alternate 7:4, fourth select 3:0). Read mode bit 0 is at 0x02 bit 2 and read mode bits 2:1 are at 0x03 bits 6:5; any write to 0x02 updates read mode bit 0. Buffer entry i is at 0x80+i for i from 0 to 70.
- R3: Writing 0x02 with bit 0 set, while enabled and with both counts at 68 or less, starts a frame. csN goes low and mosi carries the opcode, then buffer entries 0 to tx-1, then rx bytes of 0xFF, MSB first. mosi changes on falling sck and miso is sampled on rising sck.
- R4: Response byte i is stored in buffer entry (tx + i) mod 71.
- R5: If either count is above 68, execute sets a sticky error flag (0x02 bit 5) and no frame starts. The flag stays set through later frames and is cleared by writing 0x02 with bit 5 set.
- R6: While the enable bit is 0, execute has no effect: no frame starts and the error flag is not set.
- R7: The sck half-period, in engine clock cycles, is set by normal select codes as follows: 4 gives 1, 0 gives 2, 1 gives 4, 2 gives 6, 3 gives 8, and 7 gives 40. Reserved codes 5 and 6 are stored as written but clock like code 7.
- R8: From the start of a frame until csN rises, 0x02 bit 0 and 0x03 bit 7 read 1. During that time all register writes are ignored.
- R9: csN stays low for exactly 16 × half-period × (1 + tx + rx) engine clock cycles, and sck is 0 whenever csN is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Engine clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 8 | Register write data |
| regRdData | output | 8 | Register read data for regAddr (combinational) |
| sck | output | 1 | Serial clock |
| csN | output | 1 | Active-low chip select |
| mosi | output | 1 | Serial data to the flash device |
| miso | input | 1 | Serial data from the flash device |

## Verification
The assertions check properties that must hold on every cycle. sck is idle-low outside a frame, and the buffer pointer never leaves the 71-entry range. A count error or a disabled engine never leads to a running frame, and the clock half-period does not change mid-frame. Writes made while busy leave the counts untouched, speed writes land as written, and the error flag stays set until it is cleared. The byte order on mosi, the wrap of responses past entry 70, the exact chip-select low time for each speed code and the survival of buffer contents across an ignored write can only be shown by the bench. It does this with its frame scenarios and a serial device model.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int BUF_DEPTH = 71;
  localparam int IDX_W = $clog2(BUF_DEPTH);

  localparam logic [7:0] OFS_OPC   = 8'h00;
  localparam logic [7:0] OFS_CTRL2 = 8'h02;
  localparam logic [7:0] OFS_CTRL3 = 8'h03;
  localparam logic [7:0] OFS_ENA   = 8'h20;
  localparam logic [7:0] OFS_SPDLO = 8'h22;
  localparam logic [7:0] OFS_SPDHI = 8'h23;
  localparam logic [7:0] OFS_TXCNT = 8'h48;
  localparam logic [7:0] OFS_RXCNT = 8'h4B;
  localparam logic [7:0] BUF_BASE  = 8'h80;
  localparam logic [7:0] BUF_END   = 8'(BUF_BASE + BUF_DEPTH);

  typedef struct packed {
    logic             loadOp;
    logic             sampleIn;
    logic             shiftStep;
    logic             loadNext;
    logic             nextFromBuf;
    logic             storeRx;
    logic [IDX_W-1:0] storeIdx;
    logic [IDX_W-1:0] loadIdx;
    logic             errSet;
  } strobe_t;
endpackage

// File: rtl/spi_eng_dpath.sv
module spi_eng_dpath
  import spi_eng_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  input  logic       busy,
  input  strobe_t    strb,
  input  logic       miso,
  output logic       mosi,
  output logic [7:0] txCount,
  output logic [7:0] rxCount,
  output logic       engEnable,
  output logic [3:0] normSel,
  output logic       goReq
);
  logic [7:0]       opcodeReg;
  logic [15:0]      speedReg;
  logic [2:0]       readMode;
  logic             errFlag;
  logic [7:0]       shiftReg;
  logic             misoBit;
  logic [7:0]       bufMem [BUF_DEPTH];
  logic             wrOk;
  logic             inBuf;
  logic [IDX_W-1:0] bufIdx;
  logic [7:0]       assembled;
  logic             errClr;

  assign wrOk      = regWe && !busy;
  assign inBuf     = (regAddr >= BUF_BASE) && (regAddr < BUF_END);
  assign bufIdx    = IDX_W'(regAddr - BUF_BASE);
  assign goReq     = wrOk && (regAddr == OFS_CTRL2) && regWrData[0];
  assign errClr    = wrOk && (regAddr == OFS_CTRL2) && regWrData[5];
  assign normSel   = speedReg[15:12];
  assign mosi      = shiftReg[7];
  assign assembled = {shiftReg[6:0], misoBit};

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      opcodeReg <= '0;
      txCount   <= '0;
      rxCount   <= '0;
      engEnable <= 1'b0;
      speedReg  <= '0;
      readMode  <= '0;
      errFlag   <= 1'b0;
    end else begin
      if (wrOk) begin
        case (regAddr)
          OFS_OPC:   opcodeReg      <= regWrData;
          OFS_CTRL2: readMode[0]    <= regWrData[2];
          OFS_CTRL3: readMode[2:1]  <= regWrData[6:5];
          OFS_ENA:   engEnable      <= regWrData[0];
          OFS_SPDLO: speedReg[7:0]  <= regWrData;
          OFS_SPDHI: speedReg[15:8] <= regWrData;
          OFS_TXCNT: txCount        <= regWrData;
          OFS_RXCNT: rxCount        <= regWrData;
          default: ;
        endcase
      end
      if (strb.errSet)
        errFlag <= 1'b1;
      else if (errClr)
        errFlag <= 1'b0;
    end
  end

  // Data buffer: software writes when idle, response stores during a frame
  always_ff @(posedge clk) begin
    if (strb.shiftStep && strb.storeRx)
      bufMem[strb.storeIdx] <= assembled;
    else if (wrOk && inBuf)
      bufMem[bufIdx] <= regWrData;
  end

  // Serial shifter
  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      misoBit  <= 1'b0;
    end else begin
      if (strb.sampleIn)
        misoBit <= miso;
      if (strb.loadOp)
        shiftReg <= opcodeReg;
      else if (strb.shiftStep) begin
        if (strb.loadNext)
          shiftReg <= strb.nextFromBuf ? bufMem[strb.loadIdx] : 8'hFF;
        else
          shiftReg <= assembled;
      end
    end
  end

  // Register read mux
  always_comb begin
    regRdData = 8'h00;
    if (inBuf)
      regRdData = bufMem[bufIdx];
    else begin
      case (regAddr)
        OFS_OPC:   regRdData = opcodeReg;
        OFS_CTRL2: regRdData = {2'b00, errFlag, 2'b00, readMode[0], 1'b0, busy};
        OFS_CTRL3: regRdData = {busy, readMode[2:1], 5'b00000};
        OFS_ENA:   regRdData = {7'b0, engEnable};
        OFS_SPDLO: regRdData = speedReg[7:0];
        OFS_SPDHI: regRdData = speedReg[15:8];
        OFS_TXCNT: regRdData = txCount;
        OFS_RXCNT: regRdData = rxCount;
        default:   regRdData = 8'h00;
      endcase
    end
  end

  p_busy_write_ignored_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy && regWe && (regAddr == OFS_TXCNT) |=> $stable(txCount));

  p_speed_store_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy && regWe && (regAddr == OFS_SPDLO) |=> speedReg[7:0] == $past(regWrData));

  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    errFlag && !errClr |=> errFlag);
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int MAX_DATA  = 68,
  parameter int HALF_C4   = 1,
  parameter int HALF_C0   = 2,
  parameter int HALF_C1   = 4,
  parameter int HALF_C2   = 6,
  parameter int HALF_C3   = 8,
  parameter int HALF_SLOW = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       goReq,
  input  logic       engEnable,
  input  logic [7:0] txCount,
  input  logic [7:0] rxCount,
  input  logic [3:0] normSel,
  output logic       busy,
  output logic       csN,
  output logic       sck,
  output strobe_t    strb
);
  localparam int DIV_W = $clog2(HALF_SLOW + 1);
  localparam logic [7:0] MAX_B = 8'(MAX_DATA);

  function automatic logic [DIV_W-1:0] halfOf(input logic [3:0] code);
    case (code)
      4'd4:    return DIV_W'(HALF_C4);
      4'd0:    return DIV_W'(HALF_C0);
      4'd1:    return DIV_W'(HALF_C1);
      4'd2:    return DIV_W'(HALF_C2);
      4'd3:    return DIV_W'(HALF_C3);
      default: return DIV_W'(HALF_SLOW);
    endcase
  endfunction

  logic             run;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfLim;
  logic [2:0]       bitCnt;
  logic [7:0]       curByte;
  logic [IDX_W-1:0] ptr;
  logic [IDX_W-1:0] nextPtr;
  logic             countsBad, start, halfEdge, rising, falling, byteEnd, lastByte;
  logic [8:0]       frameBytes;

  assign countsBad  = (txCount > MAX_B) || (rxCount > MAX_B);
  assign start      = goReq && engEnable && !countsBad && !run;
  assign halfEdge   = run && (divCnt == halfLim - 1'b1);
  assign rising     = halfEdge && !sck;
  assign falling    = halfEdge && sck;
  assign byteEnd    = falling && (bitCnt == 3'd0);
  assign frameBytes = {1'b0, txCount} + {1'b0, rxCount};
  assign lastByte   = ({1'b0, curByte} == frameBytes);
  assign nextPtr    = (curByte == 8'd0) ? '0 :
                      (ptr == IDX_W'(BUF_DEPTH - 1)) ? '0 : ptr + 1'b1;
  assign busy       = run;

  always_comb begin
    strb             = '0;
    strb.loadOp      = start;
    strb.sampleIn    = rising;
    strb.shiftStep   = falling;
    strb.loadNext    = byteEnd && !lastByte;
    strb.nextFromBuf = curByte < txCount;
    strb.storeRx     = byteEnd && (curByte > txCount);
    strb.storeIdx    = ptr;
    strb.loadIdx     = nextPtr;
    strb.errSet      = goReq && engEnable && countsBad && !run;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      run     <= 1'b0;
      csN     <= 1'b1;
      sck     <= 1'b0;
      divCnt  <= '0;
      halfLim <= DIV_W'(HALF_C0);
      bitCnt  <= 3'd7;
      curByte <= '0;
      ptr     <= '0;
    end else if (start) begin
      run     <= 1'b1;
      csN     <= 1'b0;
      sck     <= 1'b0;
      divCnt  <= '0;
      halfLim <= halfOf(normSel);
      bitCnt  <= 3'd7;
      curByte <= '0;
      ptr     <= '0;
    end else if (run) begin
      if (halfEdge) begin
        divCnt <= '0;
        sck    <= ~sck;
        if (falling) begin
          if (bitCnt == 3'd0) begin
            if (lastByte) begin
              run <= 1'b0;
              csN <= 1'b1;
            end else begin
              curByte <= curByte + 8'd1;
              ptr     <= nextPtr;
              bitCnt  <= 3'd7;
            end
          end else begin
            bitCnt <= bitCnt - 3'd1;
          end
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  p_sck_idle_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sck);

  p_ptr_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    ptr < IDX_W'(BUF_DEPTH));

  p_err_no_start_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.errSet |=> !run);

  p_disabled_no_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    goReq && !engEnable && !run |=> !run);

  p_half_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    run && $past(run) |-> $stable(halfLim));
endmodule

// File: rtl/spi_flash_engine.sv
module spi_flash_engine
  import spi_eng_pkg::*;
#(
  parameter int MAX_DATA  = 68,
  parameter int HALF_SLOW = 40
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       regWe,
  input  logic [7:0] regAddr,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic       sck,
  output logic       csN,
  output logic       mosi,
  input  logic       miso
);
  strobe_t    strb;
  logic       busy, engEnable, goReq;
  logic [7:0] txCount, rxCount;
  logic [3:0] normSel;

  spi_eng_dpath u_dpath (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .busy(busy), .strb(strb),
    .miso(miso), .mosi(mosi), .txCount(txCount), .rxCount(rxCount),
    .engEnable(engEnable), .normSel(normSel), .goReq(goReq)
  );

  spi_eng_ctrl #(.MAX_DATA(MAX_DATA), .HALF_SLOW(HALF_SLOW)) u_ctrl (
    .clk(clk), .rstN(rstN), .goReq(goReq), .engEnable(engEnable),
    .txCount(txCount), .rxCount(rxCount), .normSel(normSel), .busy(busy),
    .csN(csN), .sck(sck), .strb(strb)
  );
endmodule

// File: tb/tb_spi_flash_engine.sv
`timescale 1ns/1ps
module tb_spi_flash_engine;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWe = 1'b0;
  logic [7:0] regAddr = 8'h00;
  logic [7:0] regWrData = 8'h00;
  logic [7:0] regRdData;
  logic       sck, csN, mosi;
  logic       miso = 1'b0;

  int nChecks = 0;
  int nFail = 0;
  int lowCnt = 0;
  int cycles = 0;
  int bitPos = 0;
  logic [7:0] cap [160];

  always #2 clk = ~clk;

  spi_flash_engine dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .sck(sck), .csN(csN),
    .mosi(mosi), .miso(miso)
  );

  // tx, rx, normal speed code
  localparam logic [19:0] VEC [7] = '{
    {8'd3, 8'd2, 4'd4}, {8'd0, 8'd4, 4'd0}, {8'd4, 8'd0, 4'd1},
    {8'd1, 8'd1, 4'd2}, {8'd2, 8'd2, 4'd3}, {8'd0, 8'd1, 4'd7},
    {8'd1, 8'd0, 4'd5}
  };

  function automatic logic [7:0] patByte(input int n);
    return 8'(n * 29 + 90);
  endfunction

  function automatic logic patBit(input int p);
    logic [7:0] b;
    b = patByte(p / 8);
    return b[7 - (p % 8)];
  endfunction

  function automatic int expHalf(input logic [3:0] code);
    case (code)
      4'd4: return 1;
      4'd0: return 2;
      4'd1: return 4;
      4'd2: return 6;
      4'd3: return 8;
      default: return 40;
    endcase
  endfunction

  // Serial device model
  always @(negedge csN) begin
    bitPos = 0;
    miso = patBit(0);
  end
  always @(posedge sck) if (!csN) begin
    cap[bitPos / 8][7 - (bitPos % 8)] = mosi;
    bitPos++;
  end
  always @(negedge sck) if (!csN) miso = patBit(bitPos);

  always @(negedge clk) begin
    cycles++;
    if (csN === 1'b0) lowCnt++;
  end

  task automatic check(input int act, input int exp, input string req);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWe = 1'b1;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic waitIdle();
    logic [7:0] v;
    do rd(8'h02, v); while (v[0]);
  endtask

  task automatic runFrame(input int tx, input int rx, input logic [3:0] code,
                          input logic [7:0] seed);
    logic [7:0] v;
    logic [7:0] opc;
    int bad;
    opc = seed ^ 8'h9C;
    wr(8'h23, {code, 4'h0});
    wr(8'h00, opc);
    wr(8'h48, 8'(tx));
    wr(8'h4B, 8'(rx));
    for (int i = 0; i < tx; i++) wr(8'h80 + 8'(i), 8'(i * 13) + seed);
    lowCnt = 0;
    wr(8'h02, 8'h01);
    waitIdle();
    check(lowCnt, 16 * (1 + tx + rx) * expHalf(code), "R7 R9 frame length");
    bad = 0;
    if (cap[0] !== opc) bad++;
    for (int i = 0; i < tx; i++) if (cap[1 + i] !== 8'(i * 13) + seed) bad++;
    for (int i = 0; i < rx; i++) if (cap[1 + tx + i] !== 8'hFF) bad++;
    check(bad, 0, "R3 mosi byte stream mismatches");
    bad = 0;
    for (int i = 0; i < rx; i++) begin
      rd(8'h80 + 8'((tx + i) % 71), v);
      if (v !== patByte(1 + tx + i)) bad++;
    end
    check(bad, 0, "R4 response placement mismatches");
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    rd(8'h00, v); check(v, 0, "R1 opcode");
    rd(8'h02, v); check(v, 0, "R1 ctrl byte 2");
    rd(8'h03, v); check(v, 0, "R1 ctrl byte 3");
    rd(8'h20, v); check(v, 0, "R1 enable");
    rd(8'h22, v); check(v, 0, "R1 speed low");
    rd(8'h23, v); check(v, 0, "R1 speed high");
    rd(8'h48, v); check(v, 0, "R1 tx count");
    rd(8'h4B, v); check(v, 0, "R1 rx count");
    check(csN, 1, "R1 csN idle");
    check(sck, 0, "R1 sck idle");

    // R2 readback
    wr(8'h02, 8'h04); rd(8'h02, v); check(v, 8'h04, "R2 read mode bit 0");
    wr(8'h03, 8'hFF); rd(8'h03, v); check(v, 8'h60, "R2 read mode bits 2:1");
    wr(8'h22, 8'hA5); rd(8'h22, v); check(v, 8'hA5, "R2 speed low byte");
    wr(8'h23, 8'h5C); rd(8'h23, v); check(v, 8'h5C, "R2 reserved code stored");
    wr(8'h86, 8'h3E); rd(8'h86, v); check(v, 8'h3E, "R2 buffer entry 6");
    wr(8'h20, 8'h01); rd(8'h20, v); check(v, 1, "R2 enable");

    // Vector table of frames
    for (int k = 0; k < 7; k++)
      runFrame(int'(VEC[k][19:12]), int'(VEC[k][11:4]), VEC[k][3:0], 8'(k * 17 + 3));

    // Opcode-only frame
    runFrame(0, 0, 4'd4, 8'h11);
    // R4 wrap past entry 70
    runFrame(68, 5, 4'd4, 8'h21);
    rd(8'h82, v); check(v, 8'(2 * 13) + 8'h21, "R4 entry 2 untouched by wrap");
    // Largest receive phase
    runFrame(0, 68, 4'd4, 8'h40);

    // R5 count error
    wr(8'h48, 8'd69); wr(8'h4B, 8'd0);
    lowCnt = 0;
    wr(8'h02, 8'h01);
    repeat (4) @(negedge clk);
    check(lowCnt, 0, "R5 no frame on tx 69");
    rd(8'h02, v); check(v, 8'h20, "R5 error flag set");
    runFrame(1, 1, 4'd4, 8'h55);
    rd(8'h02, v); check(v[5], 1, "R5 error sticky across frame");
    wr(8'h4B, 8'd70); wr(8'h48, 8'd0);
    lowCnt = 0;
    wr(8'h02, 8'h01);
    repeat (4) @(negedge clk);
    check(lowCnt, 0, "R5 no frame on rx 70");
    wr(8'h02, 8'h20); rd(8'h02, v); check(v, 0, "R5 error cleared");

    // R6 disabled engine
    wr(8'h4B, 8'd1);
    wr(8'h20, 8'h00);
    lowCnt = 0;
    wr(8'h02, 8'h01);
    repeat (4) @(negedge clk);
    check(lowCnt, 0, "R6 no frame while disabled");
    rd(8'h02, v); check(v, 0, "R6 no busy and no error");
    wr(8'h20, 8'h01);

    // R8 busy indication and ignored writes
    wr(8'h80, 8'h6A);
    wr(8'h48, 8'd1); wr(8'h4B, 8'd1); wr(8'h23, 8'h70);
    wr(8'h02, 8'h01);
    rd(8'h02, v); check(v[0], 1, "R8 execute bit reads busy");
    rd(8'h03, v); check(v[7], 1, "R8 busy bit");
    wr(8'h48, 8'h11);
    wr(8'h80, 8'h77);
    waitIdle();
    check(csN, 1, "R8 csN high after busy clears");
    rd(8'h48, v); check(v, 1, "R8 tx count write ignored");
    rd(8'h80, v); check(v, 8'h6A, "R8 buffer write ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    wait (cycles > 150000);
    nFail++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule